// File: doc/BRIEF.md
# Dual-Channel Storage Host Register Bank

This block is the control and status register file of a two-channel storage host controller. It sits on a plain register bus with a 9-bit byte address, 32-bit data, separate read and write strobes and four byte enables. Each channel has its own set of registers: a bus-master command byte, a bus-master status byte, a 6-bit scratch byte, a 12-bit link control word, a 16-bit interrupt enable field and a configuration/status word. Two summary words pack the command, interrupt and status bits of both channels so that one read collects them. A link status word reports whether a device is attached.

The status byte holds three kinds of bit. Bits 6:5 are written directly. Bit 0 copies the DMA engine's active level and cannot be written from the bus. Bits 1 and 2 are sticky flags that the bus clears by writing a one. Bit 1 is set by a DMA error pulse, and bit 2 is set when the channel interrupt input rises. The channel interrupt input is registered into bit 11 of the configuration/status word. The block interrupt output is the OR of both channels' registered bits.

Each channel has a two-state reset sequencer. It starts in RS_PULSE under global reset and moves RS_PULSE→RS_IDLE on the first clock with no request. It moves RS_IDLE→RS_PULSE when a link control write sets bit 0, and it stays in RS_PULSE while requests keep arriving. The channel's reset output is high exactly while its sequencer is in RS_PULSE.

Top module: `dcr_bank`

## Requirements
- R1: While the global reset `rst_n` is low, both `chan_rst_pulse` bits are 1, and they stay 1 for the first cycle after its release. After reset every register reads 0, except the configuration/status words, which read 0x65150000.
- R2: A status write (channel 0 at 0x02 or 0x12, channel 1 at 0x0A or 0x1A, data in `wdata[7:0]`) stores bits 6:5 from the data. It clears bit 1 and bit 2 where the data bit is 1, keeps them where it is 0, clears bits 7, 4 and 3, and leaves bit 0 alone.
- R3: Status bit 0 equals the channel's `dma_active` input as sampled at the previous clock. A `dma_error` high at a clock sets bit 1. A 0→1 change of `chan_irq_in` sets bit 2. A set wins over a clearing write in the same cycle.
- R4: The command byte is written from `wdata[7:0]` at 0x00 or 0x10 (channel 0) and at 0x08 or 0x18 (channel 1). It reads back at 0x00 and 0x08.
- R5: The scratch byte stores `wdata[5:0]` at 0x01 or 0x11 (channel 0) and at 0x09 or 0x19 (channel 1). It reads back at 0x01 and 0x09 with bits 7:6 at zero.
- R6: The link control word (0x100 for channel 0, 0x180 for channel 1) keeps bits 11:0 of a write. Lane 0 supplies bits 7:0 and lane 1 supplies bits 11:8.
- R7: A link control write with byte enable 0 set and `wdata[0]`=1 drives that channel's `chan_rst_pulse` bit high for the next cycle only, unless another such write follows.
- R8: The interrupt enable field (0x148 for channel 0, 0x1C8 for channel 1) stores `wdata[31:16]` masked with 0x3EED (lanes 2 and 3). It reads back in bits 31:16.
- R9: The configuration/status word (0xA0 for channel 0, 0xE0 for channel 1) reads 0x65150000 with bit 11 equal to `chan_irq_in` as sampled at the previous clock. `irq_out` is the OR of both channels' bit 11.
- R10: A read at 0x10 returns channel 0's command byte in bits 7:0. Bit 4 is ORed with channel 0's bit 11 and bit 6 with channel 1's bit 11. Bit 14 holds channel 1's status bit 2, bits 23:16 hold channel 0's status and bits 31:24 hold channel 1's status.
- R11: A read at 0x18 returns channel 1's command byte in bits 7:0, with bit 4 ORed with channel 1's bit 11, and channel 1's status in bits 23:16.
- R12: The link status word (0x104 for channel 0, 0x184 for channel 1) reads 0x113 when that channel's `dev_present` bit is 1 and 0 otherwise.
- R13: `rdata` is valid in the same cycle as `rd_en`. Reads of 0x03, 0x0B, the write-only aliases 0x11, 0x12, 0x19 and 0x1A, and every unmapped offset return 0. `rdata` is 0 while `rd_en` is low.
- R14: A byte register write with byte enable 0 low leaves that register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 9 | Byte address |
| wdata | input | 32 | Write data |
| be | input | 4 | Write byte enables |
| rdata | output | 32 | Read data, combinational |
| dev_present | input | 2 | Device attached, per channel |
| chan_irq_in | input | 2 | Channel interrupt request levels |
| dma_active | input | 2 | DMA engine active level, per channel |
| dma_error | input | 2 | DMA error event pulses, per channel |
| chan_rst_pulse | output | 2 | Per-channel reset pulse |
| irq_out | output | 1 | Combined interrupt |

## Verification
The status byte is swept over all 256 write values on both channels and both aliases, with bits 1 and 2 set beforehand. A design that cleared on a written zero, let bit 0 be written, or kept bits 7, 4 or 3 would return the wrong byte. A same-cycle error event and clearing write checks set priority; a design where the clear won would lose the error flag. Every one of the 512 offsets is read against a bench model, so a decode on the wrong address, a missing alias or a stray nonzero read stands out. The reset output is watched one cycle at a time after reset and after link writes, so a stretched or missing pulse, or a pulse from a write with bit 0 clear, is reported.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int NCH    = 2;
    localparam int ADDR_W = 9;
    localparam int DW     = 32;
    localparam int BE_W   = DW / 8;
    localparam int SCR_W  = 6;
    localparam int LCTL_W = 12;
    localparam int IEN_W  = 16;

    localparam logic [DW-1:0]    CFG_RST_VAL  = 32'h6515_0000;
    localparam logic [IEN_W-1:0] IEN_MASK     = 16'h3EED;
    localparam logic [DW-1:0]    LINK_UP_CODE = 32'h0000_0113;
    localparam int               CFG_IRQ_BIT  = 11;

    typedef enum logic {RS_IDLE, RS_PULSE} rs_state_t;

    typedef struct packed {
        logic [7:0]        cmd;
        logic [7:0]        sts;
        logic [SCR_W-1:0]  scr;
        logic [LCTL_W-1:0] lctl;
        logic [IEN_W-1:0]  ien;
        logic              irq;
    } chan_view_t;

    // byte registers: 8 bytes per channel, second alias window 16 bytes up
    function automatic logic [ADDR_W-1:0] bm_off(int ch, int win, int idx);
        return ADDR_W'(8 * ch + 16 * win + idx);
    endfunction

    function automatic logic [ADDR_W-1:0] cfg_off(int ch);
        return ADDR_W'(32'h0A0 + 32'h40 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] lctl_off(int ch);
        return ADDR_W'(32'h100 + 32'h80 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] lsts_off(int ch);
        return ADDR_W'(32'h104 + 32'h80 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] ien_off(int ch);
        return ADDR_W'(32'h148 + 32'h80 * ch);
    endfunction
endpackage

// File: rtl/dcr_rst_fsm.sv
module dcr_rst_fsm
    import dcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic pulse
);
    rs_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_PULSE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RS_IDLE:  state_d = req ? RS_PULSE : RS_IDLE;
            RS_PULSE: state_d = req ? RS_PULSE : RS_IDLE;
            default:  state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        pulse = (state_q == RS_PULSE);
    end
endmodule

// File: rtl/dcr_chan.sv
module dcr_chan
    import dcr_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [BE_W-1:0]   be,
    input  logic              dma_active,
    input  logic              dma_error,
    input  logic              irq_in,
    output chan_view_t        view,
    output logic              rst_req
);
    localparam logic [ADDR_W-1:0] OFF_CMD_A = bm_off(CH, 0, 0);
    localparam logic [ADDR_W-1:0] OFF_CMD_B = bm_off(CH, 1, 0);
    localparam logic [ADDR_W-1:0] OFF_SCR_A = bm_off(CH, 0, 1);
    localparam logic [ADDR_W-1:0] OFF_SCR_B = bm_off(CH, 1, 1);
    localparam logic [ADDR_W-1:0] OFF_STS_A = bm_off(CH, 0, 2);
    localparam logic [ADDR_W-1:0] OFF_STS_B = bm_off(CH, 1, 2);
    localparam logic [ADDR_W-1:0] OFF_LCTL  = lctl_off(CH);
    localparam logic [ADDR_W-1:0] OFF_IEN   = ien_off(CH);

    logic [7:0]        cmd_q, sts_q, sts_base, sts_d;
    logic [SCR_W-1:0]  scr_q;
    logic [LCTL_W-1:0] lctl_q;
    logic [IEN_W-1:0]  ien_q;
    logic              irq_q;
    logic              byte_wr, hit_cmd, hit_scr, hit_sts, hit_lctl, hit_ien;
    logic              irq_rise;
    logic [7:0]        wbyte;

    assign wbyte    = wdata[7:0];
    assign byte_wr  = wr_en & be[0];
    assign hit_cmd  = byte_wr && (addr == OFF_CMD_A || addr == OFF_CMD_B);
    assign hit_scr  = byte_wr && (addr == OFF_SCR_A || addr == OFF_SCR_B);
    assign hit_sts  = byte_wr && (addr == OFF_STS_A || addr == OFF_STS_B);
    assign hit_lctl = wr_en && (addr == OFF_LCTL);
    assign hit_ien  = wr_en && (addr == OFF_IEN);
    assign irq_rise = irq_in & ~irq_q;
    assign rst_req  = hit_lctl & be[0] & wdata[0];

    // bus write first, then hardware sets on top so a set is never lost
    always_comb begin
        sts_base = sts_q;
        if (hit_sts) begin
            sts_base = (wbyte & 8'h60) | (sts_q & 8'h06 & ~wbyte);
        end
        sts_d    = sts_base;
        sts_d[0] = dma_active;
        sts_d[1] = sts_base[1] | dma_error;
        sts_d[2] = sts_base[2] | irq_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            sts_q  <= '0;
            scr_q  <= '0;
            lctl_q <= '0;
            ien_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            sts_q <= sts_d;
            irq_q <= irq_in;
            if (hit_cmd) cmd_q <= wbyte;
            if (hit_scr) scr_q <= wbyte[SCR_W-1:0];
            if (hit_lctl && be[0]) lctl_q[7:0] <= wdata[7:0];
            if (hit_lctl && be[1]) lctl_q[LCTL_W-1:8] <= wdata[LCTL_W-1:8];
            if (hit_ien && be[2]) ien_q[7:0] <= wdata[23:16] & IEN_MASK[7:0];
            if (hit_ien && be[3]) ien_q[15:8] <= wdata[31:24] & IEN_MASK[15:8];
        end
    end

    always_comb begin
        view.cmd  = cmd_q;
        view.sts  = sts_q;
        view.scr  = scr_q;
        view.lctl = lctl_q;
        view.ien  = ien_q;
        view.irq  = irq_q;
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata[15:LCTL_W];
endmodule

// File: rtl/dcr_rdmux.sv
module dcr_rdmux
    import dcr_pkg::*;
(
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  chan_view_t [NCH-1:0]      views,
    input  logic [NCH-1:0]            dev_present,
    output logic [DW-1:0]             rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == bm_off(c, 0, 0)) rdata = {24'h0, views[c].cmd};
                if (addr == bm_off(c, 0, 1)) rdata = {26'h0, views[c].scr};
                if (addr == bm_off(c, 0, 2)) rdata = {24'h0, views[c].sts};
                if (addr == cfg_off(c)) begin
                    rdata = CFG_RST_VAL;
                    rdata[CFG_IRQ_BIT] = views[c].irq;
                end
                if (addr == lctl_off(c)) rdata = {20'h0, views[c].lctl};
                if (addr == lsts_off(c)) rdata = dev_present[c] ? LINK_UP_CODE : '0;
                if (addr == ien_off(c))  rdata = {views[c].ien, 16'h0};
            end
            if (addr == ADDR_W'(16)) begin
                rdata = {views[1].sts, views[0].sts, 8'h0, views[0].cmd};
                rdata[4]  = views[0].cmd[4] | views[0].irq;
                rdata[6]  = views[0].cmd[6] | views[1].irq;
                rdata[14] = views[1].sts[2];
            end
            if (addr == ADDR_W'(24)) begin
                rdata = {8'h0, views[1].sts, 8'h0, views[1].cmd};
                rdata[4] = views[1].cmd[4] | views[1].irq;
            end
        end
    end
endmodule

// File: rtl/dcr_bank.sv
module dcr_bank
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [BE_W-1:0]   be,
    output logic [DW-1:0]     rdata,
    input  logic [NCH-1:0]    dev_present,
    input  logic [NCH-1:0]    chan_irq_in,
    input  logic [NCH-1:0]    dma_active,
    input  logic [NCH-1:0]    dma_error,
    output logic [NCH-1:0]    chan_rst_pulse,
    output logic              irq_out
);
    chan_view_t [NCH-1:0] views;
    logic [NCH-1:0]       rst_req;
    logic [NCH-1:0]       irq_vec;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dcr_chan #(.CH(g)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en),
            .addr       (addr),
            .wdata      (wdata),
            .be         (be),
            .dma_active (dma_active[g]),
            .dma_error  (dma_error[g]),
            .irq_in     (chan_irq_in[g]),
            .view       (views[g]),
            .rst_req    (rst_req[g])
        );

        dcr_rst_fsm u_rst (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (rst_req[g]),
            .pulse (chan_rst_pulse[g])
        );

        assign irq_vec[g] = views[g].irq;
    end

    dcr_rdmux u_rdmux (
        .rd_en       (rd_en),
        .addr        (addr),
        .views       (views),
        .dev_present (dev_present),
        .rdata       (rdata)
    );

    assign irq_out = |irq_vec;
endmodule

// File: rtl/dcr_bank_chk.sv
module dcr_bank_chk
    import dcr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [BE_W-1:0]   be,
    input logic [DW-1:0]     rdata,
    input logic [NCH-1:0]    dev_present,
    input logic [NCH-1:0]    chan_irq_in,
    input logic [NCH-1:0]    dma_active,
    input logic [NCH-1:0]    dma_error,
    input logic [NCH-1:0]    chan_rst_pulse,
    input logic              irq_out
);
    logic started;
    logic req0, req1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    assign req0 = wr_en && be[0] && wdata[0] && (addr == 9'h100);
    assign req1 = wr_en && be[0] && wdata[0] && (addr == 9'h180);

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (irq_out == $past(|chan_irq_in)));

    a_r7_pulse_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        req0 |=> chan_rst_pulse[0]);

    a_r7_pulse_ch1: assert property (@(posedge clk) disable iff (!rst_n)
        req1 |=> chan_rst_pulse[1]);

    a_r7_single_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst_pulse[0] && !req0) |=> !chan_rst_pulse[0]);

    a_r7_single_ch1: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst_pulse[1] && !req1) |=> !chan_rst_pulse[1]);

    a_r13_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

    a_r13_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 9'h003 || addr == 9'h00B)) |-> (rdata == '0));

    a_r12_link_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 9'h104) |-> (rdata == (dev_present[0] ? 32'h113 : 32'h0)));

    logic unused_chk;
    assign unused_chk = ^{dma_active, dma_error};
endmodule

bind dcr_bank dcr_bank_chk u_chk (.*);

// File: tb/dcr_bank_tb.sv
module dcr_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic [1:0]  dev_present = '0, chan_irq_in = '0, dma_active = '0, dma_error = '0;
    logic [1:0]  chan_rst_pulse;
    logic        irq_out;

    int checks = 0, errors = 0;

    logic [7:0]  m_cmd [2];
    logic [7:0]  m_st  [2];
    logic [5:0]  m_scr [2];
    logic [11:0] m_lc  [2];
    logic [15:0] m_ien [2];
    logic        m_irq [2];

    always #10 clk = ~clk;

    dcr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .be(be), .rdata(rdata), .dev_present(dev_present),
        .chan_irq_in(chan_irq_in), .dma_active(dma_active), .dma_error(dma_error),
        .chan_rst_pulse(chan_rst_pulse), .irq_out(irq_out)
    );

    // bench reference model, built from the requirements
    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                m_cmd[c] = 0; m_st[c] = 0; m_scr[c] = 0;
                m_lc[c] = 0; m_ien[c] = 0; m_irq[c] = 0;
            end else begin
                logic [7:0] st;
                st = m_st[c];
                if (wr_en && be[0] && (addr == 9'(8*c) || addr == 9'(8*c+16))) m_cmd[c] = wdata[7:0];
                if (wr_en && be[0] && (addr == 9'(8*c+1) || addr == 9'(8*c+17))) m_scr[c] = wdata[5:0];
                if (wr_en && be[0] && (addr == 9'(8*c+2) || addr == 9'(8*c+18)))
                    st = (wdata[7:0] & 8'h60) | (st & 8'h06 & ~wdata[7:0]);
                st[0] = dma_active[c];
                if (dma_error[c]) st[1] = 1'b1;
                if (chan_irq_in[c] && !m_irq[c]) st[2] = 1'b1;
                m_st[c] = st;
                m_irq[c] = chan_irq_in[c];
                if (wr_en && addr == 9'(256+128*c)) begin
                    if (be[0]) m_lc[c][7:0]  = wdata[7:0];
                    if (be[1]) m_lc[c][11:8] = wdata[11:8];
                end
                if (wr_en && addr == 9'(328+128*c)) begin
                    if (be[2]) m_ien[c][7:0]  = wdata[23:16];
                    if (be[3]) m_ien[c][15:8] = wdata[31:24];
                    m_ien[c] = m_ien[c] & 16'h3EED;
                end
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [8:0] a);
        logic [31:0] r = 0;
        for (int c = 0; c < 2; c++) begin
            if (a == 9'(8*c))         r = {24'h0, m_cmd[c]};
            if (a == 9'(8*c+1))       r = {26'h0, m_scr[c]};
            if (a == 9'(8*c+2))       r = {24'h0, m_st[c]};
            if (a == 9'(160+64*c))    r = 32'h6515_0000 | (32'(m_irq[c]) << 11);
            if (a == 9'(256+128*c))   r = {20'h0, m_lc[c]};
            if (a == 9'(260+128*c))   r = dev_present[c] ? 32'h113 : 32'h0;
            if (a == 9'(328+128*c))   r = {m_ien[c], 16'h0};
        end
        if (a == 9'd16)
            r = {m_st[1], m_st[0], 8'h0, m_cmd[0]} | (32'(m_irq[0]) << 4)
                | (32'(m_irq[1]) << 6) | (32'(m_st[1][2]) << 14);
        if (a == 9'd24)
            r = {8'h0, m_st[1], 8'h0, m_cmd[1]} | (32'(m_irq[1]) << 4);
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(logic [8:0] a, string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        chk($sformatf("%s addr %h", tag, a), rdata, exp_read(a));
        #1 rd_en = 1'b0;
    endtask

    task automatic tick(logic w, logic [8:0] a, logic [31:0] d, logic [3:0] b);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; be = b;
        @(posedge clk);
        #1 wr_en = 1'b0; be = 4'h0;
    endtask

    task automatic sweep_all(string tag);
        for (int a = 0; a < 512; a++) rd(9'(a), tag);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pulse in reset", {30'h0, chan_rst_pulse}, 32'h3);
        rst_n = 1'b1;
        #1 chk("R1 pulse first cycle", {30'h0, chan_rst_pulse}, 32'h3);
        @(negedge clk);
        chk("R1 pulse ends", {30'h0, chan_rst_pulse}, 32'h0);
        sweep_all("R1 R13 reset map");

        // R4 command bytes, both aliases
        for (int v = 0; v < 256; v++) begin
            tick(1, v[0] ? 9'h010 : 9'h000, 32'(v), 4'h1);
            tick(1, v[1] ? 9'h018 : 9'h008, 32'(255 - v), 4'h1);
            rd(9'h000, "R4");
            rd(9'h008, "R4");
        end

        // R5 scratch bytes
        for (int v = 0; v < 256; v++) begin
            tick(1, v[2] ? 9'h011 : 9'h001, 32'(v) | 32'hFFFF_FF00, 4'h1);
            tick(1, v[3] ? 9'h019 : 9'h009, 32'(v ^ 8'h5A), 4'h1);
            rd(9'h001, "R5");
            rd(9'h009, "R5");
        end

        // R2 R3 status sweep with sticky bits set beforehand
        for (int v = 0; v < 256; v++) begin
            for (int c = 0; c < 2; c++) begin
                @(negedge clk);
                dma_error[c] = 1'b1; chan_irq_in[c] = 1'b1; dma_active[c] = v[3];
                tick(0, 9'h000, 0, 4'h0);
                @(negedge clk);
                dma_error[c] = 1'b0; chan_irq_in[c] = 1'b0;
                tick(0, 9'h000, 0, 4'h0);
                rd(9'(8*c+2), "R3 sets");
                tick(1, 9'(8*c + 2 + (v[0] ? 16 : 0)), 32'(v), 4'h1);
                rd(9'(8*c+2), "R2 status write");
                if (v % 16 == 5) begin
                    rd(9'h010, "R10 summary");
                    rd(9'h018, "R11 summary");
                end
            end
        end

        // R3 set wins over clear in the same cycle
        @(negedge clk);
        dma_error = 2'b11;
        tick(1, 9'h002, 32'h06, 4'h1);
        @(negedge clk);
        dma_error = 2'b00;
        rd(9'h002, "R3 set priority");
        chk("R3 set priority bit1", {31'h0, exp_read(9'h002)[1]}, 32'h1);

        // R14 byte enable 0 low
        tick(1, 9'h000, 32'hAB, 4'hE);
        rd(9'h000, "R14 cmd");
        tick(1, 9'h009, 32'h3F, 4'h2);
        rd(9'h009, "R14 scratch");
        tick(1, 9'h00A, 32'h06, 4'hE);
        rd(9'h00A, "R14 status");

        // R6 R7 link control and reset pulse
        for (int i = 0; i < 12; i++) begin
            for (int c = 0; c < 2; c++) begin
                logic [31:0] val;
                val = 32'hA5C3_0F00 ^ (32'(i) * 32'h1357_9BDF);
                val[0] = i[0];
                tick(1, 9'(256 + 128*c), val, 4'hF);
                @(negedge clk);
                chk("R7 pulse", {31'h0, chan_rst_pulse[c]}, {31'h0, val[0]});
                chk("R7 other channel quiet", {31'h0, chan_rst_pulse[1-c]}, 32'h0);
                @(negedge clk);
                chk("R7 pulse single", {31'h0, chan_rst_pulse[c]}, 32'h0);
                rd(9'(256 + 128*c), "R6");
            end
        end
        tick(1, 9'h100, 32'hFFF, 4'h2);
        rd(9'h100, "R6 lane1");
        @(negedge clk);
        chk("R7 no pulse without lane0", {30'h0, chan_rst_pulse}, 32'h0);

        // R8 interrupt enable
        for (int i = 0; i < 10; i++) begin
            tick(1, 9'h148, 32'hFFFF_1234 ^ (32'(i) * 32'h2F1D_0000), 4'hF);
            tick(1, 9'h1C8, 32'h0F0F_FFFF + (32'(i) << 20), i[0] ? 4'h8 : 4'hC);
            rd(9'h148, "R8");
            rd(9'h1C8, "R8");
        end

        // R9 interrupts and summary views
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chan_irq_in = 2'(k);
            tick(0, 9'h000, 0, 4'h0);
            @(negedge clk);
            chk("R9 irq_out", {31'h0, irq_out}, {31'h0, |2'(k)});
            rd(9'h0A0, "R9");
            rd(9'h0E0, "R9");
            rd(9'h010, "R10");
            rd(9'h018, "R11");
        end

        // R12 link status
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            dev_present = 2'(k);
            rd(9'h104, "R12");
            rd(9'h184, "R12");
        end

        // R13 full map with a busy state, and idle read bus
        chan_irq_in = 2'b10;
        dev_present = 2'b11;
        tick(0, 9'h000, 0, 4'h0);
        sweep_all("R13 map");
        @(negedge clk);
        rd_en = 1'b0; addr = 9'h0A0;
        #1 chk("R13 idle rdata", rdata, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule